// File: doc/BRIEF.md
# Scratchpad Data Memory and Address Resolver

This block is the internal data store of a small accumulator-style microcontroller core. It holds a 256-byte scratchpad RAM and three special-function registers: the stack pointer, the program status byte and the port 2 output latch. The core's decoder presents one access request per clock. Each request carries an access mode and an 8-bit operand. The block turns that operand into a physical location, returns the addressed byte or bit in the same cycle, and commits any write at the next clock edge.

Eight modes are supported. A working register is taken relative to the bank that the status byte selects. A direct address picks lower RAM or the register space. An indirect access goes through a pointer register and can reach the whole RAM. A bit operand folds onto a byte and a bit position. Push and pop go through the stack pointer. Two modes build a 16-bit external data address, either from a pointer register paged by the port 2 latch or from one of two 16-bit pointer inputs. The block does not run the external bus cycle. It only supplies the address.

Top module: `idata_unit`

## Requirements
- R1: After reset, the stack pointer is 07h, the status byte is 00h, the port 2 latch is FFh and every RAM byte is 00h.
- R2: Register mode (req_mode=0) reaches RAM byte bank*8+n. Here n is req_addr[2:0] and bank is status bits [4:3].
- R3: Direct mode (req_mode=1) uses RAM when req_addr is below 80h. From 80h upward it uses the register space: stack pointer at 81h, port 2 latch at A0h, status byte at D0h.
- R4: A direct or bit access to any other address at 80h or above reads as 00h and leaves every register unchanged when written.
- R5: Indirect mode (req_mode=2) uses as its address the content of R0 or R1 in the active bank, chosen by req_addr[0]. It reaches all 256 RAM bytes, and RAM 80h–FFh is separate from the register space.
- R6: Bit mode (req_mode=3) maps operands below 80h to RAM byte 20h+req_addr[6:3] and maps higher operands to register {req_addr[7:3],000b}. In both cases the bit is req_addr[2:0]. rd_bit shows that bit. A write replaces only that bit, and the new byte can be read on the next cycle.
- R7: Push (req_mode=4) increments the stack pointer and writes req_wdata at the new value. Pop (req_mode=5) returns the byte at the current stack pointer on rd_data and then decrements the pointer. The pointer wraps modulo 256.
- R8: External-register mode (req_mode=6) drives ext_addr = {port 2 latch, content of R0/R1 chosen by req_addr[0]}.
- R9: External-pointer mode (req_mode=7) drives ext_addr from dptr1 when dptr_sel=1 and from dptr0 otherwise. The port 2 latch has no effect on it.
- R10: rd_data shows the addressed location in the cycle the request is present. Writes take effect at the following clock edge. With req_valid low, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Access mode (0..7) |
| req_addr | input | 8 | Register index, direct address, bit operand or pointer select |
| req_we | input | 1 | Write for register, direct, indirect and bit modes |
| req_wdata | input | 8 | Write byte (also the push data) |
| req_bitval | input | 1 | Bit value for a bit write |
| dptr_sel | input | 1 | Selects dptr1 over dptr0 |
| dptr0 | input | 16 | First 16-bit external pointer |
| dptr1 | input | 16 | Second 16-bit external pointer |
| rd_data | output | 8 | Byte at the resolved location |
| rd_bit | output | 1 | Addressed bit in bit mode |
| ext_addr | output | 16 | External data address |

## Verification
A push updates the stack pointer and writes a RAM byte in the same cycle, and that byte can be a working register of the current bank. The bench provokes this directly: with the reset pointer, it pushes, selects bank 1 through a bit write to the status byte, and reads R0 in register mode. Random mixes of direct writes to the pointer and status byte among pushes and pops cover the same overlap. The bench judges the result against a reference model that applies the pointer step and the RAM write as one update.

// File: rtl/idata_pkg.sv
package idata_pkg;
    typedef enum logic [2:0] {
        M_REG  = 3'd0,
        M_DIR  = 3'd1,
        M_IND  = 3'd2,
        M_BIT  = 3'd3,
        M_PUSH = 3'd4,
        M_POP  = 3'd5,
        M_XRI  = 3'd6,
        M_XDP  = 3'd7
    } acc_mode_e;

    localparam logic [7:0] SFR_SP  = 8'h81;
    localparam logic [7:0] SFR_P2  = 8'hA0;
    localparam logic [7:0] SFR_PSW = 8'hD0;

    typedef struct packed {
        logic [7:0] sp;
        logic [7:0] psw;
        logic [7:0] p2;
    } core_regs_t;
endpackage

// File: rtl/idata_ram.sv
module idata_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/idata_resolve.sv
module idata_resolve
    import idata_pkg::*;
#(
    parameter int AW = 8,
    parameter int XW = 16
) (
    input  acc_mode_e     mode,
    input  logic [AW-1:0] opnd,
    input  logic [1:0]    bank,
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] page,
    input  logic          dp_sel,
    input  logic [XW-1:0] dp0,
    input  logic [XW-1:0] dp1,
    output logic          is_ram,
    output logic [AW-1:0] loc,
    output logic [2:0]    bit_idx,
    output logic [XW-1:0] ext_addr
);
    localparam logic [AW-1:0] BIT_BASE = AW'(8'h20);

    always_comb begin
        is_ram  = 1'b1;
        loc     = ptr;
        bit_idx = opnd[2:0];
        case (mode)
            M_REG:  loc = AW'({bank, opnd[2:0]});
            M_DIR: begin
                is_ram = ~opnd[AW-1];
                loc    = opnd;
            end
            M_BIT: begin
                if (!opnd[AW-1]) begin
                    loc = BIT_BASE + AW'(opnd[6:3]);
                end else begin
                    is_ram = 1'b0;
                    loc    = {opnd[AW-1:3], 3'b000};
                end
            end
            M_PUSH: loc = sp + AW'(1);
            M_POP:  loc = sp;
            default: loc = ptr;
        endcase
    end

    always_comb begin
        if (mode == M_XDP) ext_addr = dp_sel ? dp1 : dp0;
        else               ext_addr = XW'({page, ptr});
    end
endmodule

// File: rtl/idata_unit.sv
module idata_unit
    import idata_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          XW       = 16,
    parameter logic [7:0]  SP_RST   = 8'h07,
    parameter logic [7:0]  PSW_RST  = 8'h00,
    parameter logic [7:0]  P2_RST   = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_mode,
    input  logic [7:0]    req_addr,
    input  logic          req_we,
    input  logic [7:0]    req_wdata,
    input  logic          req_bitval,
    input  logic          dptr_sel,
    input  logic [15:0]   dptr0,
    input  logic [15:0]   dptr1,
    output logic [7:0]    rd_data,
    output logic          rd_bit,
    output logic [15:0]   ext_addr
);
    core_regs_t regs_d, regs_q;
    acc_mode_e  mode;
    logic       is_ram;
    logic [7:0] loc, ram_rd, ptr_val, sfr_rd, cur_byte, merged, wbyte;
    logic [7:0] ptr_loc;
    logic [2:0] bit_idx;
    logic       ram_we;
    logic [1:0] bank;

    assign mode    = acc_mode_e'(req_mode);
    assign bank    = regs_q.psw[4:3];
    assign ptr_loc = {3'b000, bank, 2'b00, req_addr[0]};

    idata_resolve #(.AW(AW), .XW(XW)) u_res (
        .mode(mode), .opnd(req_addr), .bank(bank), .sp(regs_q.sp),
        .ptr(ptr_val), .page(regs_q.p2), .dp_sel(dptr_sel),
        .dp0(dptr0), .dp1(dptr1), .is_ram(is_ram), .loc(loc),
        .bit_idx(bit_idx), .ext_addr(ext_addr)
    );

    idata_ram #(.AW(AW), .DW(8)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(loc), .wdata(wbyte),
        .raddr_a(loc), .rdata_a(ram_rd), .raddr_b(ptr_loc), .rdata_b(ptr_val)
    );

    always_comb begin
        case (loc)
            SFR_SP:  sfr_rd = regs_q.sp;
            SFR_P2:  sfr_rd = regs_q.p2;
            SFR_PSW: sfr_rd = regs_q.psw;
            default: sfr_rd = 8'h00;
        endcase
    end

    assign cur_byte = is_ram ? ram_rd : sfr_rd;
    assign rd_data  = cur_byte;
    assign rd_bit   = cur_byte[bit_idx];

    always_comb begin
        merged          = cur_byte;
        merged[bit_idx] = req_bitval;
    end
    assign wbyte = (mode == M_BIT) ? merged : req_wdata;

    always_comb begin
        regs_d = regs_q;
        ram_we = 1'b0;
        if (req_valid) begin
            case (mode)
                M_REG, M_IND: ram_we = req_we;
                M_DIR, M_BIT: begin
                    if (req_we) begin
                        if (is_ram) begin
                            ram_we = 1'b1;
                        end else begin
                            case (loc)
                                SFR_SP:  regs_d.sp  = wbyte;
                                SFR_P2:  regs_d.p2  = wbyte;
                                SFR_PSW: regs_d.psw = wbyte;
                                default: ;
                            endcase
                        end
                    end
                end
                M_PUSH: begin
                    regs_d.sp = regs_q.sp + 8'd1;
                    ram_we    = 1'b1;
                end
                M_POP: regs_d.sp = regs_q.sp - 8'd1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.sp  <= SP_RST;
            regs_q.psw <= PSW_RST;
            regs_q.p2  <= P2_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R7
    push_sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode == M_PUSH |=> regs_q.sp == $past(regs_q.sp) + 8'd1);

    // R7
    pop_sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode == M_POP |=> regs_q.sp == $past(regs_q.sp) - 8'd1);

    // R4
    unimpl_sfr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_we && (mode == M_DIR) && req_addr[7] &&
        req_addr != SFR_SP && req_addr != SFR_P2 && req_addr != SFR_PSW
        |=> $stable(regs_q));

    // R10
    idle_regs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(regs_q));

    // R2
    reg_bank_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == M_REG |-> is_ram && loc < 8'd32);

    // R6
    bit_ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == M_BIT && !req_addr[7] |-> is_ram && loc >= 8'h20 && loc <= 8'h2F);
endmodule

// File: tb/idata_unit_tb.sv
module idata_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [7:0]  req_addr = '0;
    logic        req_we = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        req_bitval = 1'b0;
    logic        dptr_sel = 1'b0;
    logic [15:0] dptr0 = '0;
    logic [15:0] dptr1 = '0;
    logic [7:0]  rd_data;
    logic        rd_bit;
    logic [15:0] ext_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_ram [256];
    logic [7:0] m_sp, m_psw, m_p2;

    always #10 clk = ~clk;

    idata_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .req_bitval(req_bitval), .dptr_sel(dptr_sel), .dptr0(dptr0),
        .dptr1(dptr1), .rd_data(rd_data), .rd_bit(rd_bit), .ext_addr(ext_addr)
    );

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4, 3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [7:0] sfr_get(input logic [7:0] a);
        if (a == 8'h81) return m_sp;
        if (a == 8'hA0) return m_p2;
        if (a == 8'hD0) return m_psw;
        return 8'h00;
    endfunction

    function automatic int reg_slot(input logic [2:0] n);
        return int'(m_psw[4:3]) * 8 + int'(n);
    endfunction

    // byte the model expects at the location a request resolves to
    function automatic logic [7:0] exp_byte(input logic [2:0] m, input logic [7:0] a);
        case (m)
            3'd0: return m_ram[reg_slot(a[2:0])];
            3'd1: return a < 8'h80 ? m_ram[a] : sfr_get(a);
            3'd2: return m_ram[m_ram[reg_slot({2'b00, a[0]})]];
            3'd3: return a < 8'h80 ? m_ram[8'h20 + {4'h0, a[6:3]}] : sfr_get({a[7:3], 3'b000});
            3'd5: return m_ram[m_sp];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check8(input string t, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic model_update(input logic [2:0] m, input logic [7:0] a, input logic we,
                                input logic [7:0] wd, input logic bv);
        logic [7:0] b;
        case (m)
            3'd0: if (we) m_ram[reg_slot(a[2:0])] = wd;
            3'd2: if (we) m_ram[m_ram[reg_slot({2'b00, a[0]})]] = wd;
            3'd1, 3'd3: if (we) begin
                logic [7:0] tgt;
                if (m == 3'd1) begin
                    tgt = a; b = wd;
                end else begin
                    tgt = a < 8'h80 ? 8'h20 + {4'h0, a[6:3]} : {a[7:3], 3'b000};
                    b = exp_byte(m, a);
                    b[a[2:0]] = bv;
                end
                if (tgt < 8'h80 && m == 3'd1) m_ram[tgt] = b;
                else if (m == 3'd3 && a < 8'h80) m_ram[tgt] = b;
                else if (tgt == 8'h81) m_sp = b;
                else if (tgt == 8'hA0) m_p2 = b;
                else if (tgt == 8'hD0) m_psw = b;
            end
            3'd4: begin m_sp = m_sp + 8'd1; m_ram[m_sp] = wd; end
            3'd5: m_sp = m_sp - 8'd1;
            default: ;
        endcase
    endtask

    // one request: drive at falling edge, check mid-low phase, commit at rising edge
    task automatic do_req(input logic v, input logic [2:0] m, input logic [7:0] a,
                          input logic we, input logic [7:0] wd, input logic bv,
                          input string t);
        string tg;
        tg = (t == "") ? tag_of(m) : t;
        req_valid = v; req_mode = m; req_addr = a; req_we = we;
        req_wdata = wd; req_bitval = bv;
        #5;
        if (v) begin
            if (m <= 3'd3 || m == 3'd5) check8(tg, {8'h00, rd_data}, {8'h00, exp_byte(m, a)});
            if (m == 3'd3) check8(tg, {15'd0, rd_bit}, {15'd0, exp_byte(m, a)[a[2:0]]});
            if (m == 3'd6) check8(tg, ext_addr, {m_p2, m_ram[reg_slot({2'b00, a[0]})]});
            if (m == 3'd7) check8(tg, ext_addr, dptr_sel ? dptr1 : dptr0);
        end
        @(posedge clk);
        if (v) model_update(m, a, we, wd, bv);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) m_ram[i] = 8'h00;
        m_sp = 8'h07; m_psw = 8'h00; m_p2 = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_req(1, 3'd1, 8'h81, 0, 0, 0, "R1");
        do_req(1, 3'd1, 8'hD0, 0, 0, 0, "R1");
        do_req(1, 3'd1, 8'hA0, 0, 0, 0, "R1");
        do_req(1, 3'd2, 8'h00, 0, 0, 0, "R1");

        // R7 push at reset SP lands in bank 1 R0; R2 bank via status bit 3 (D3h)
        do_req(1, 3'd4, 8'h00, 0, 8'h5A, 0, "R7");
        do_req(1, 3'd3, 8'hD3, 1, 0, 1, "R6");
        do_req(1, 3'd0, 8'h00, 0, 0, 0, "R2");
        do_req(1, 3'd1, 8'h81, 0, 0, 0, "R7");
        do_req(1, 3'd5, 8'h00, 0, 0, 0, "R7");

        // R7 wrap: SP=00 then pop -> FF, push -> 00
        do_req(1, 3'd1, 8'h81, 1, 8'h00, 0, "R3");
        do_req(1, 3'd5, 8'h00, 0, 0, 0, "R7");
        do_req(1, 3'd1, 8'h81, 0, 0, 0, "R7");
        do_req(1, 3'd4, 8'h00, 0, 8'hC3, 0, "R7");
        do_req(1, 3'd1, 8'h00, 0, 0, 0, "R7");

        // R5 upper RAM separate from SFR space
        do_req(1, 3'd0, 8'h01, 1, 8'hA0, 0, "R5");
        do_req(1, 3'd2, 8'h01, 1, 8'h77, 0, "R5");
        do_req(1, 3'd2, 8'h01, 0, 0, 0, "R5");
        do_req(1, 3'd1, 8'hA0, 0, 0, 0, "R5");

        // R4 unimplemented SFR
        do_req(1, 3'd1, 8'h99, 1, 8'h3C, 0, "R4");
        do_req(1, 3'd1, 8'h99, 0, 0, 0, "R4");
        do_req(1, 3'd3, 8'hB7, 1, 0, 1, "R4");
        do_req(1, 3'd3, 8'hB7, 0, 0, 0, "R4");

        // R6 bit 00h -> LSB of 20h, bit A7h -> MSB of port 2
        do_req(1, 3'd3, 8'h00, 1, 0, 1, "R6");
        do_req(1, 3'd1, 8'h20, 0, 0, 0, "R6");
        do_req(1, 3'd3, 8'hA7, 1, 0, 0, "R6");
        do_req(1, 3'd1, 8'hA0, 0, 0, 0, "R6");

        // R8 / R9 external address, port 2 ignored by pointer mode
        do_req(1, 3'd6, 8'h01, 0, 0, 0, "R8");
        dptr0 = 16'h1234; dptr1 = 16'hBEEF; dptr_sel = 1'b1;
        do_req(1, 3'd7, 8'h00, 0, 0, 0, "R9");
        do_req(1, 3'd1, 8'hA0, 1, 8'h11, 0, "R9");
        do_req(1, 3'd7, 8'h00, 0, 0, 0, "R9");

        // R10 idle request leaves state alone
        do_req(0, 3'd1, 8'h81, 1, 8'hEE, 0, "R10");
        do_req(1, 3'd1, 8'h81, 0, 0, 0, "R10");

        for (int k = 0; k < 3000; k++) begin
            logic [2:0] m;
            logic [7:0] a;
            logic [7:0] pick;
            m = 3'($urandom_range(0, 7));
            a = 8'($urandom);
            pick = 8'($urandom_range(0, 9));
            if (m == 3'd1 && pick < 3) a = (pick == 0) ? 8'h81 : (pick == 1) ? 8'hD0 : 8'hA0;
            dptr_sel = 1'($urandom);
            dptr0 = 16'($urandom);
            dptr1 = 16'($urandom);
            do_req(($urandom_range(0, 9) != 0), m, a, 1'($urandom),
                   8'($urandom), 1'($urandom), "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule